// File: doc/BRIEF.md
# Phase/Frequency Comparator with Charge-Pump Control

This block compares two divider outputs: the reference divider pulse train (`refIn`) and the programmable divider pulse train (`progIn`). Both inputs are sampled on the system clock. A rising edge on either one sets an up or a down flag. When both flags would be set together, both clear. The flag state drives two charge-pump control outputs. Each pump output is a drive-enable and value pair, so that the high-impedance state is visible. The flag state also drives two push-pull signals meant for an external charge pump.

The `polarity` input reverses the sense of every comparator output, and it also selects which divider signal is mirrored on `testOut`. The second pump output only drives while the serial latch strobe `latchIn` is high. Power-save disables both pump outputs and clears the detector. A lock indicator rises once a programmable number of reference edges have passed with no flag active.

Top module: `pfd_phase_comparator`

## Requirements
- R1: With `polarity`=1 and the up flag set (reference edge seen first), `pumpMainEn`=1, `pumpMainVal`=1, `extRefDrv`=0 and `extProgDrv`=0.
- R2: With `polarity`=1 and the down flag set (programmable edge seen first), `pumpMainEn`=1, `pumpMainVal`=0, `extRefDrv`=1 and `extProgDrv`=1.
- R3: With no flag set, both pump enables are 0 (high impedance), `extRefDrv`=0 and `extProgDrv`=1, for either polarity.
- R4: With `polarity`=0 the senses swap. The up flag gives `pumpMainVal`=0 with both external drives 1. The down flag gives `pumpMainVal`=1 with both external drives 0.
- R5: A rising edge of `refIn` sets the up flag and a rising edge of `progIn` sets the down flag, one clock after the input is first sampled high. A set flag holds after its input falls. The other input's rising edge clears both flags, and edges in the same cycle set neither flag.
- R6: `testOut` equals `refIn` while `polarity`=1 and equals `progIn` while `polarity`=0.
- R7: `pumpGatedEn` is 1 only when `pumpMainEn` is 1 and `latchIn` is 1. While it drives, `pumpGatedVal` equals `pumpMainVal`.
- R8: While `powerSave`=1 both pump enables are 0, both flags are cleared and the lock count returns to zero. Edges seen during power-save leave no flag behind.
- R9: `lockOut` rises after `LOCK_COUNT` (default 4) reference rising edges with no flag active. It falls on the clock after any flag becomes active.
- R10: After reset both flags are clear, both pump enables are 0 and `lockOut`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refIn | input | 1 | Reference divider output |
| progIn | input | 1 | Programmable divider output |
| polarity | input | 1 | Output sense select (1 = normal, 0 = inverted) |
| latchIn | input | 1 | Serial latch strobe; enables the gated pump output |
| powerSave | input | 1 | Power-save request, active high |
| pumpMainEn | output | 1 | Drive enable of the always-operating pump output |
| pumpMainVal | output | 1 | Drive value of the always-operating pump output |
| pumpGatedEn | output | 1 | Drive enable of the latch-gated pump output |
| pumpGatedVal | output | 1 | Drive value of the latch-gated pump output |
| extRefDrv | output | 1 | Reference-side signal for an external charge pump |
| extProgDrv | output | 1 | Programmable-side signal for an external charge pump |
| testOut | output | 1 | Monitor of the divider signal chosen by polarity |
| lockOut | output | 1 | Lock indication |

## Verification
The power-save clear and a divider edge can fall in the same cycle. The bench raises `refIn` in the same cycle that `powerSave` is asserted. It then checks that no up flag remains once power-save is released: the pump stays in high impedance and the external drives sit at neutral. A second collision is a reference edge that advances the lock count while a flag from the previous window is still set. The bench leaves a flag pending at a lock boundary and checks that `lockOut` is low on the following cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Per-cycle strobes from the edge control to the comparator datapath
  typedef struct packed {
    logic refEdge;   // rising edge of the reference divider signal
    logic progEdge;  // rising edge of the programmable divider signal
    logic flush;     // clear flags and lock state (power-save)
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_edge_ctrl.sv
module pfd_edge_ctrl
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       progIn,
  input  logic       powerSave,
  output pfdStrobe_t strobe
);
  logic refPrev;
  logic progPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev  <= 1'b0;
      progPrev <= 1'b0;
    end else begin
      refPrev  <= refIn;
      progPrev <= progIn;
    end
  end

  always_comb begin
    strobe.refEdge  = refIn & ~refPrev & ~powerSave;
    strobe.progEdge = progIn & ~progPrev & ~powerSave;
    strobe.flush    = powerSave;
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int LOCK_COUNT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strobe,
  input  logic       refIn,
  input  logic       progIn,
  input  logic       polarity,
  input  logic       latchIn,
  input  logic       powerSave,
  output logic       pumpMainEn,
  output logic       pumpMainVal,
  output logic       pumpGatedEn,
  output logic       pumpGatedVal,
  output logic       extRefDrv,
  output logic       extProgDrv,
  output logic       testOut,
  output logic       lockOut,
  output logic       upFlag,
  output logic       dnFlag
);
  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [CW-1:0] LOCK_MAX = CW'(LOCK_COUNT);

  logic          upNext;
  logic          dnNext;
  logic [CW-1:0] quietCnt;
  logic          active;

  // Two-flag up/down detector; both set together means both clear
  always_comb begin
    upNext = upFlag | strobe.refEdge;
    dnNext = dnFlag | strobe.progEdge;
    if (upNext && dnNext) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upFlag <= 1'b0;
      dnFlag <= 1'b0;
    end else if (strobe.flush) begin
      upFlag <= 1'b0;
      dnFlag <= 1'b0;
    end else begin
      upFlag <= upNext;
      dnFlag <= dnNext;
    end
  end

  assign active = upFlag | dnFlag;

  // Lock counter: reference edges with no flag active, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
    end else if (strobe.flush || active) begin
      quietCnt <= '0;
    end else if (strobe.refEdge && quietCnt != LOCK_MAX) begin
      quietCnt <= quietCnt + 1'b1;
    end
  end

  assign lockOut = (quietCnt == LOCK_MAX);

  // Output encoding, sense chosen by polarity
  always_comb begin
    pumpMainEn   = active & ~powerSave;
    pumpMainVal  = polarity ? upFlag : dnFlag;
    pumpGatedEn  = pumpMainEn & latchIn;
    pumpGatedVal = pumpMainVal;
    extRefDrv    = polarity ? dnFlag : upFlag;
    extProgDrv   = polarity ? ~upFlag : ~dnFlag;
    testOut      = polarity ? refIn : progIn;
  end
endmodule

// File: rtl/pfd_phase_comparator.sv
module pfd_phase_comparator
  import pfd_pkg::*;
#(
  parameter int LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic progIn,
  input  logic polarity,
  input  logic latchIn,
  input  logic powerSave,
  output logic pumpMainEn,
  output logic pumpMainVal,
  output logic pumpGatedEn,
  output logic pumpGatedVal,
  output logic extRefDrv,
  output logic extProgDrv,
  output logic testOut,
  output logic lockOut
);
  pfdStrobe_t strobe;
  logic       upFlag;
  logic       dnFlag;

  pfd_edge_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refIn     (refIn),
    .progIn    (progIn),
    .powerSave (powerSave),
    .strobe    (strobe)
  );

  pfd_core #(.LOCK_COUNT(LOCK_COUNT)) u_core (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .refIn        (refIn),
    .progIn       (progIn),
    .polarity     (polarity),
    .latchIn      (latchIn),
    .powerSave    (powerSave),
    .pumpMainEn   (pumpMainEn),
    .pumpMainVal  (pumpMainVal),
    .pumpGatedEn  (pumpGatedEn),
    .pumpGatedVal (pumpGatedVal),
    .extRefDrv    (extRefDrv),
    .extProgDrv   (extProgDrv),
    .testOut      (testOut),
    .lockOut      (lockOut),
    .upFlag       (upFlag),
    .dnFlag       (dnFlag)
  );
endmodule

// File: rtl/pfd_phase_comparator_chk.sv
module pfd_phase_comparator_chk (
  input logic clk,
  input logic rstN,
  input logic latchIn,
  input logic powerSave,
  input logic pumpMainEn,
  input logic pumpMainVal,
  input logic pumpGatedEn,
  input logic pumpGatedVal,
  input logic extRefDrv,
  input logic extProgDrv,
  input logic lockOut,
  input logic upFlag,
  input logic dnFlag
);
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(upFlag && dnFlag));

  // R3
  neutral_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!upFlag && !dnFlag) |-> (!pumpMainEn && !extRefDrv && extProgDrv));

  // R7
  gated_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pumpGatedEn |-> (pumpMainEn && latchIn && pumpGatedVal == pumpMainVal));

  // R8
  powersave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |=> (!upFlag && !dnFlag && !lockOut));

  // R8
  powersave_pump_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |-> (!pumpMainEn && !pumpGatedEn));

  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upFlag || dnFlag) |=> !lockOut);
endmodule

bind pfd_phase_comparator pfd_phase_comparator_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .latchIn      (latchIn),
  .powerSave    (powerSave),
  .pumpMainEn   (pumpMainEn),
  .pumpMainVal  (pumpMainVal),
  .pumpGatedEn  (pumpGatedEn),
  .pumpGatedVal (pumpGatedVal),
  .extRefDrv    (extRefDrv),
  .extProgDrv   (extProgDrv),
  .lockOut      (lockOut),
  .upFlag       (upFlag),
  .dnFlag       (dnFlag)
);

// File: tb/pfd_phase_comparator_test.sv
module pfd_phase_comparator_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0, progIn = 1'b0, polarity = 1'b1, latchIn = 1'b0, powerSave = 1'b0;
  logic pumpMainEn, pumpMainVal, pumpGatedEn, pumpGatedVal;
  logic extRefDrv, extProgDrv, testOut, lockOut;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pfd_phase_comparator #(.LOCK_COUNT(4)) uut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .progIn(progIn),
    .polarity(polarity), .latchIn(latchIn), .powerSave(powerSave),
    .pumpMainEn(pumpMainEn), .pumpMainVal(pumpMainVal),
    .pumpGatedEn(pumpGatedEn), .pumpGatedVal(pumpGatedVal),
    .extRefDrv(extRefDrv), .extProgDrv(extProgDrv),
    .testOut(testOut), .lockOut(lockOut)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // pump en/val, external drives
  task automatic chkOut(input string req, input logic en, input logic val,
                        input logic er, input logic ep);
    chk(req, "pumpMainEn", pumpMainEn, en);
    if (en) chk(req, "pumpMainVal", pumpMainVal, val);
    chk(req, "extRefDrv", extRefDrv, er);
    chk(req, "extProgDrv", extProgDrv, ep);
  endtask

  task automatic pulseRef();
    refIn = 1'b1; step(); refIn = 1'b0; step();
  endtask

  task automatic pulseProg();
    progIn = 1'b1; step(); progIn = 1'b0; step();
  endtask

  task automatic testReset();
    chkOut("R10", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10", "pumpGatedEn", pumpGatedEn, 1'b0);
    chk("R10", "lockOut", lockOut, 1'b0);
  endtask

  task automatic testLock();
    for (int i = 0; i < 3; i++) begin
      refIn = 1'b1; progIn = 1'b1; step();
      refIn = 1'b0; progIn = 1'b0; step();
    end
    chk("R9", "lockOut after 3 quiet edges", lockOut, 1'b0);
    chkOut("R5", 1'b0, 1'b0, 1'b0, 1'b1);
    refIn = 1'b1; progIn = 1'b1; step();
    chk("R9", "lockOut after 4 quiet edges", lockOut, 1'b1);
    refIn = 1'b0; progIn = 1'b0; step();
    // reference edge with flag pending: up flag set, lock falls next clock
    refIn = 1'b1; step();
    chk("R9", "lockOut in flag cycle", lockOut, 1'b1);
    refIn = 1'b0; step();
    chk("R9", "lockOut after flag", lockOut, 1'b0);
    pulseProg();
  endtask

  task automatic testNormalSense();
    polarity = 1'b1;
    refIn = 1'b1; step();
    chkOut("R1", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", "testOut follows ref", testOut, 1'b1);
    refIn = 1'b0; step();
    chkOut("R5", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", "testOut follows ref low", testOut, 1'b0);
    progIn = 1'b1; step();
    chkOut("R5", 1'b0, 1'b0, 1'b0, 1'b1);
    progIn = 1'b0; step();
    progIn = 1'b1; step();
    chkOut("R2", 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", "testOut ignores prog", testOut, 1'b0);
    progIn = 1'b0; step();
    pulseRef();
    chkOut("R3", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testInvertedSense();
    polarity = 1'b0;
    step();
    chkOut("R3", 1'b0, 1'b0, 1'b0, 1'b1);
    refIn = 1'b1; step();
    chkOut("R4", 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", "testOut ignores ref", testOut, 1'b0);
    refIn = 1'b0; step();
    pulseProg();
    progIn = 1'b1; step();
    chkOut("R4", 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", "testOut follows prog", testOut, 1'b1);
    progIn = 1'b0; step();
    pulseRef();
    polarity = 1'b1;
    step();
  endtask

  task automatic testGated();
    latchIn = 1'b0;
    refIn = 1'b1; step();
    chk("R7", "gated off with latch low", pumpGatedEn, 1'b0);
    latchIn = 1'b1; #1;
    chk("R7", "gated on with latch high", pumpGatedEn, 1'b1);
    chk("R7", "gated value", pumpGatedVal, 1'b1);
    refIn = 1'b0; step();
    pulseProg();
    chk("R7", "gated off when idle", pumpGatedEn, 1'b0);
    latchIn = 1'b0;
  endtask

  task automatic testPowerSave();
    latchIn = 1'b1;
    refIn = 1'b1; step();
    powerSave = 1'b1; #1;
    chk("R8", "main pump off", pumpMainEn, 1'b0);
    chk("R8", "gated pump off", pumpGatedEn, 1'b0);
    refIn = 1'b0; step();
    // reference edge arrives during power-save
    refIn = 1'b1; step();
    refIn = 1'b0; step();
    powerSave = 1'b0; step();
    chkOut("R8", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8", "lockOut cleared", lockOut, 1'b0);
    latchIn = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testLock();
    testNormalSense();
    testInvertedSense();
    testGated();
    testPowerSave();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule